// File: doc/BRIEF.md
# Processor Control and Debug Register Bank

This block keeps the control and status state of a 32-bit RISC core and answers the core's two control-register instructions. The instruction decoder passes in a 5-bit register number (instruction bits 25:21) and a read or write strobe. A read returns the selected value in the same cycle so that it can go to the destination register. A write takes its data from the source register and updates the state at the next clock edge. Any access that names an unknown register, reads a write-only register, writes a read-only register, or names a debug slot beyond the configured count raises an illegal-instruction flag in the same cycle. A flagged access changes no state.

The bank holds the interrupt enable, mask and pending registers, a free-running cycle counter, a constant configuration word, the exception and debug-exception base addresses, a debug control word, and a configurable number (zero to four) of instruction breakpoints and data watchpoints. On every cycle it compares the fetch address with each enabled breakpoint, and each load or store address with each armed watchpoint. Any match produces a one-cycle debug-hit pulse on the following cycle. A combined interrupt request output is derived from the registered enable, mask and pending state, so a write to any of them is seen by the next instruction.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset, every stored register reads zero, the cycle counter restarts from zero, and `irq_req`, `dbg_hit` and `csr_illegal` are low.
- R2: The register numbers and their access rights are:
  - 0x00: enable, read/write, bits 2:0.
  - 0x01: mask, read/write, IRQ_W bits.
  - 0x02: pending, read and write-one-to-clear.
  - 0x03 and 0x04: cache-invalidate strobes, write-only, no stored state.
  - 0x05: cycle counter, read-only.
  - 0x06: configuration, read-only.
  - 0x07: exception base, read/write.
  - 0x08: debug control, read/write.
  - 0x09: debug-exception base, read/write.
  - 0x10+n: breakpoint n, write-only.
  - 0x18+n: watchpoint n, write-only.

  Read data appears in the same cycle as `csr_rd`, and bits above a register's width read as zero.
- R3: `csr_illegal` is raised combinationally, in the cycle of the access, when any of these holds:
  - the number is not listed in R2;
  - the access reads a write-only register;
  - the access writes a read-only register;
  - the access names breakpoint n with n >= NUM_BP, or watchpoint n with n >= NUM_WP.

  A flagged write changes no state, and a flagged read returns zero.
- R4: Each pending bit is set on any clock edge where its `irq_in` line is high, and stays set until a write to 0x02 with a 1 in that bit position. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R5: `irq_req` is high when enable bit 0 is set and any pending bit is also set in the mask. It comes from registers only, so it reflects a write to 0x00, 0x01 or 0x02 from the cycle after that write.
- R6: The cycle counter advances by one on every clock edge and wraps modulo 2^32. A write to it is illegal and does not disturb the count.
- R7: The configuration word holds NUM_BP in bits 3:0 and NUM_WP in bits 7:4. All other bits are zero.
- R8: Bit 0 of a breakpoint register enables it. An enabled breakpoint matches when `fetch_pc[31:2]` equals its stored bits 31:2. `dbg_hit` is high in the cycle after a matching cycle and for one cycle per matching cycle.
- R9: Watchpoint n takes its mode from debug-control bits [2n+1:2n]: 0 off, 1 loads, 2 stores, 3 both. It matches when the access kind is armed and `data_addr[31:2]` equals its stored bits 31:2. The match feeds `dbg_hit` with the same one-cycle delay as R8.
- R10: The two base-address registers store bits 31:BASE_LSB (8 by default), and their lower bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_sel | input | 5 | Register number from instruction bits 25:21 |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data from the source register |
| csr_rdata | output | 32 | Read data for the destination register |
| csr_illegal | output | 1 | Illegal-instruction flag for the current access |
| irq_in | input | IRQ_W | Level interrupt lines |
| irq_req | output | 1 | Interrupt request to the core |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| data_addr | input | 32 | Load/store address |
| data_rd | input | 1 | Load in progress |
| data_wr | input | 1 | Store in progress |
| dbg_hit | output | 1 | Breakpoint or watchpoint match, one cycle late |

## Verification
The assertions assume that `csr_sel`, the strobes and the data-bus flags are defined whenever reset is released. They also assume that a write to the pending register sees only its own data, with no guarantee about simultaneous interrupt levels beyond the set-wins rule. The stimulus raises at most one CSR strobe per cycle and drives every input a fixed time after the clock edge. It returns the strobes, `irq_in` and the bus flags to idle after each cycle, and it parks `fetch_pc` at an address no breakpoint ever holds. A hit is therefore caused only by the cycle under test.

// File: rtl/creg_pkg.sv
package creg_pkg;

   // Register numbers; the slot groups are decoded from bits 4:2.
   typedef enum logic [4:0] {
      CSR_IE   = 5'h00,
      CSR_IM   = 5'h01,
      CSR_IP   = 5'h02,
      CSR_ICC  = 5'h03,
      CSR_DCC  = 5'h04,
      CSR_CC   = 5'h05,
      CSR_CFG  = 5'h06,
      CSR_EBA  = 5'h07,
      CSR_DC   = 5'h08,
      CSR_DEBA = 5'h09
   } csr_id_e;

   localparam int         MAX_SLOTS = 4;
   localparam int         SLOT_W    = $clog2(MAX_SLOTS);
   localparam logic [2:0] BP_GROUP  = 3'b100;
   localparam logic [2:0] WP_GROUP  = 3'b110;

   typedef enum logic [1:0] {
      WM_OFF   = 2'd0,
      WM_READ  = 2'd1,
      WM_WRITE = 2'd2,
      WM_BOTH  = 2'd3
   } wmode_e;

endpackage

// File: rtl/creg_irq.sv
module creg_irq #(
   parameter int IRQ_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ie,
   input  logic             wr_im,
   input  logic             wr_ip,
   input  logic [31:0]      wdata,
   input  logic [IRQ_W-1:0] irq_in,
   output logic [2:0]       ie,
   output logic [IRQ_W-1:0] im,
   output logic [IRQ_W-1:0] ip,
   output logic             irq_req
);

   logic [2:0]       ie_q;
   logic [IRQ_W-1:0] im_q;
   logic [IRQ_W-1:0] ip_q;
   logic [IRQ_W-1:0] clr_mask;
   logic             unused_wd;

   assign unused_wd = ^wdata;
   assign clr_mask  = wr_ip ? wdata[IRQ_W-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q <= '0;
         im_q <= '0;
         ip_q <= '0;
      end else begin
         if (wr_ie) ie_q <= wdata[2:0];
         if (wr_im) im_q <= wdata[IRQ_W-1:0];
         // set beats clear when both hit one bit
         ip_q <= (ip_q & ~clr_mask) | irq_in;
      end
   end

   assign ie      = ie_q;
   assign im      = im_q;
   assign ip      = ip_q;
   assign irq_req = ie_q[0] & (|(ip_q & im_q));

   // R4: pending bits only fall through a write to the pending register
   a_r4_ip_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ip |=> (($past(ip_q) & ~ip_q) == '0))
      else $error("pending bit dropped without a clear");

   // R4: a clear with no incoming level leaves the written bits at zero
   a_r4_ip_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ip && irq_in == '0) |=> ((ip_q & $past(wdata[IRQ_W-1:0])) == '0))
      else $error("write-one-to-clear failed");

endmodule

// File: rtl/creg_bkpt.sv
module creg_bkpt
   import creg_pkg::*;
#(
   parameter int NUM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] slot,
   input  logic [31:0]       wdata,
   input  logic [31:0]       fetch_pc,
   output logic              hit
);

   logic unused_in;
   assign unused_in = ^{fetch_pc[1:0], wdata[1], clk, rst_n, wr_en, slot};

   if (NUM > 0) begin : g_on
      logic [NUM-1:0] match;
      logic [NUM-1:0] armed;

      for (genvar i = 0; i < NUM; i++) begin : g_slot
         logic [31:2] addr_q;
         logic        en_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr_q <= '0;
               en_q   <= 1'b0;
            end else if (wr_en && slot == SLOT_W'(i)) begin
               addr_q <= wdata[31:2];
               en_q   <= wdata[0];
            end
         end

         assign armed[i] = en_q;
         assign match[i] = en_q && (addr_q == fetch_pc[31:2]);
      end

      assign hit = |match;

      // R8: a match can only come from a slot whose enable bit is set
      a_r8_needs_enable : assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> (armed != '0))
         else $error("breakpoint hit with no slot enabled");
   end else begin : g_off
      assign hit = 1'b0;
   end

endmodule

// File: rtl/creg_wpt.sv
module creg_wpt
   import creg_pkg::*;
#(
   parameter int NUM = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [SLOT_W-1:0]      slot,
   input  logic [31:0]            wdata,
   input  logic [2*MAX_SLOTS-1:0] modes,
   input  logic [31:0]            data_addr,
   input  logic                   data_rd,
   input  logic                   data_wr,
   output logic                   hit
);

   logic unused_in;
   assign unused_in = ^{modes, wdata[1:0], data_addr[1:0], clk, rst_n, wr_en, slot};

   if (NUM > 0) begin : g_on
      logic [NUM-1:0] match;

      for (genvar i = 0; i < NUM; i++) begin : g_slot
         logic [31:2] addr_q;
         wmode_e      mode;
         logic        kind_ok;

         always_ff @(posedge clk) begin
            if (!rst_n)
               addr_q <= '0;
            else if (wr_en && slot == SLOT_W'(i))
               addr_q <= wdata[31:2];
         end

         assign mode = wmode_e'(modes[2*i +: 2]);

         always_comb begin
            case (mode)
               WM_READ:  kind_ok = data_rd;
               WM_WRITE: kind_ok = data_wr;
               WM_BOTH:  kind_ok = data_rd | data_wr;
               default:  kind_ok = 1'b0;
            endcase
         end

         assign match[i] = kind_ok && (addr_q == data_addr[31:2]);
      end

      assign hit = |match;
   end else begin : g_off
      assign hit = 1'b0;
   end

   // R9: with no load or store on the bus no watchpoint can fire
   a_r9_quiet_bus : assert property (@(posedge clk) disable iff (!rst_n)
      !(data_rd || data_wr) |-> !hit)
      else $error("watchpoint hit without bus access");

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
   import creg_pkg::*;
#(
   parameter int NUM_BP   = 4,
   parameter int NUM_WP   = 4,
   parameter int IRQ_W    = 32,
   parameter int BASE_LSB = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       csr_sel,
   input  logic             csr_rd,
   input  logic             csr_wr,
   input  logic [31:0]      csr_wdata,
   output logic [31:0]      csr_rdata,
   output logic             csr_illegal,
   input  logic [IRQ_W-1:0] irq_in,
   output logic             irq_req,
   input  logic [31:0]      fetch_pc,
   input  logic [31:0]      data_addr,
   input  logic             data_rd,
   input  logic             data_wr,
   output logic             dbg_hit
);

   localparam logic [31:0] CFG_WORD = {24'd0, 4'(NUM_WP), 4'(NUM_BP)};

   if (NUM_BP < 0 || NUM_BP > MAX_SLOTS) begin : g_bad_bp
      $error("NUM_BP must be 0..4");
   end
   if (NUM_WP < 0 || NUM_WP > MAX_SLOTS) begin : g_bad_wp
      $error("NUM_WP must be 0..4");
   end
   if (IRQ_W < 1 || IRQ_W > 32) begin : g_bad_irq
      $error("IRQ_W must be 1..32");
   end
   if (BASE_LSB < 1 || BASE_LSB > 31) begin : g_bad_base
      $error("BASE_LSB must be 1..31");
   end

   // ---------------- access decode ----------------
   logic [SLOT_W-1:0] slot;
   logic              in_bp, in_wp;
   logic              rd_ok, wr_ok, wr_go;

   assign slot  = csr_sel[SLOT_W-1:0];
   assign in_bp = (csr_sel[4:2] == BP_GROUP);
   assign in_wp = (csr_sel[4:2] == WP_GROUP);

   always_comb begin
      rd_ok = 1'b0;
      wr_ok = 1'b0;
      case (csr_sel)
         CSR_IE, CSR_IM, CSR_IP, CSR_EBA, CSR_DC, CSR_DEBA: begin
            rd_ok = 1'b1;
            wr_ok = 1'b1;
         end
         CSR_ICC, CSR_DCC: wr_ok = 1'b1;
         CSR_CC, CSR_CFG:  rd_ok = 1'b1;
         default: begin
            if (in_bp && 32'(slot) < NUM_BP) wr_ok = 1'b1;
            if (in_wp && 32'(slot) < NUM_WP) wr_ok = 1'b1;
         end
      endcase
   end

   assign csr_illegal = (csr_rd & ~rd_ok) | (csr_wr & ~wr_ok);
   assign wr_go       = csr_wr & ~csr_illegal;

   // ---------------- local registers ----------------
   logic [31:0]         cc_q;
   logic [31:BASE_LSB]  eba_q, deba_q;
   logic [31:0]         dc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cc_q   <= '0;
         eba_q  <= '0;
         deba_q <= '0;
         dc_q   <= '0;
      end else begin
         cc_q <= cc_q + 32'd1;
         if (wr_go && csr_sel == CSR_EBA)  eba_q  <= csr_wdata[31:BASE_LSB];
         if (wr_go && csr_sel == CSR_DEBA) deba_q <= csr_wdata[31:BASE_LSB];
         if (wr_go && csr_sel == CSR_DC)   dc_q   <= csr_wdata;
      end
   end

   // ---------------- interrupt state ----------------
   logic [2:0]       ie;
   logic [IRQ_W-1:0] im, ip;

   creg_irq #(.IRQ_W(IRQ_W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ie   (wr_go && csr_sel == CSR_IE),
      .wr_im   (wr_go && csr_sel == CSR_IM),
      .wr_ip   (wr_go && csr_sel == CSR_IP),
      .wdata   (csr_wdata),
      .irq_in  (irq_in),
      .ie      (ie),
      .im      (im),
      .ip      (ip),
      .irq_req (irq_req)
   );

   // ---------------- debug comparators ----------------
   logic bp_hit, wp_hit, hit_q;

   creg_bkpt #(.NUM(NUM_BP)) u_bkpt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_go && in_bp),
      .slot     (slot),
      .wdata    (csr_wdata),
      .fetch_pc (fetch_pc),
      .hit      (bp_hit)
   );

   creg_wpt #(.NUM(NUM_WP)) u_wpt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_go && in_wp),
      .slot      (slot),
      .wdata     (csr_wdata),
      .modes     (dc_q[2*MAX_SLOTS-1:0]),
      .data_addr (data_addr),
      .data_rd   (data_rd),
      .data_wr   (data_wr),
      .hit       (wp_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= bp_hit | wp_hit;
   end

   assign dbg_hit = hit_q;

   // ---------------- read path ----------------
   logic [31:0] rd_val;

   always_comb begin
      case (csr_sel)
         CSR_IE:   rd_val = 32'(ie);
         CSR_IM:   rd_val = 32'(im);
         CSR_IP:   rd_val = 32'(ip);
         CSR_CC:   rd_val = cc_q;
         CSR_CFG:  rd_val = CFG_WORD;
         CSR_EBA:  rd_val = {eba_q,  {BASE_LSB{1'b0}}};
         CSR_DEBA: rd_val = {deba_q, {BASE_LSB{1'b0}}};
         CSR_DC:   rd_val = dc_q;
         default:  rd_val = '0;
      endcase
   end

   assign csr_rdata = (csr_rd && !csr_illegal) ? rd_val : '0;

   // R6: the counter steps by exactly one per edge
   a_r6_cc_step : assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cc_q == $past(cc_q) + 32'd1))
      else $error("cycle counter skipped");

   // R3: a refused write leaves the exception base alone
   a_r3_bad_wr_keeps_base : assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_illegal) |=> $stable(eba_q))
      else $error("illegal write changed state");

   // R3: a refused read returns zero
   a_r3_bad_rd_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && csr_illegal) |-> (csr_rdata == 32'd0))
      else $error("illegal read returned data");

   // R8: the hit output is never held longer than its cause
   a_r8_hit_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      (!bp_hit && !wp_hit) |=> !dbg_hit)
      else $error("debug hit without a match");

endmodule

// File: tb/sim_ctl_reg_bank.sv
module sim_ctl_reg_bank;

   localparam int NBP = 3;
   localparam int NWP = 2;
   localparam int IW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    csr_sel = '0;
   logic          csr_rd = 1'b0, csr_wr = 1'b0;
   logic [31:0]   csr_wdata = '0;
   logic [31:0]   csr_rdata;
   logic          csr_illegal;
   logic [IW-1:0] irq_in = '0;
   logic          irq_req;
   logic [31:0]   fetch_pc = 32'hFFFF_FFF0;
   logic [31:0]   data_addr = '0;
   logic          data_rd = 1'b0, data_wr = 1'b0;
   logic          dbg_hit;

   always #4 clk = ~clk;

   ctl_reg_bank #(.NUM_BP(NBP), .NUM_WP(NWP), .IRQ_W(IW)) u0 (
      .clk, .rst_n, .csr_sel, .csr_rd, .csr_wr, .csr_wdata, .csr_rdata,
      .csr_illegal, .irq_in, .irq_req, .fetch_pc, .data_addr, .data_rd,
      .data_wr, .dbg_hit
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   logic [31:0] c_rdata;
   logic        c_ill, c_irq, c_hit, p_irq, p_hit;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one cycle: comb outputs sampled before the edge, registered ones after
   task automatic cyc();
      #2;
      c_rdata = csr_rdata; c_ill = csr_illegal; c_irq = irq_req; c_hit = dbg_hit;
      @(posedge clk); #1;
      p_irq = irq_req; p_hit = dbg_hit;
      csr_wr = 0; csr_rd = 0; csr_wdata = '0; irq_in = '0;
      data_rd = 0; data_wr = 0; data_addr = '0; fetch_pc = 32'hFFFF_FFF0;
   endtask

   task automatic wr(input logic [4:0] s, input logic [31:0] d);
      csr_sel = s; csr_wdata = d; csr_wr = 1'b1; cyc();
   endtask

   task automatic rd(input logic [4:0] s);
      csr_sel = s; csr_rd = 1'b1; cyc();
   endtask

   // {wr, rd, sel, wdata, expected rdata, expected illegal}
   localparam int NV = 21;
   localparam logic [71:0] VEC [NV] = '{
      {1'b1, 1'b0, 5'h07, 32'h1234_56FF, 32'h0,         1'b0}, // R10
      {1'b0, 1'b1, 5'h07, 32'h0,         32'h1234_5600, 1'b0}, // R10
      {1'b1, 1'b0, 5'h09, 32'hFFFF_FFFF, 32'h0,         1'b0},
      {1'b0, 1'b1, 5'h09, 32'h0,         32'hFFFF_FF00, 1'b0}, // R10
      {1'b1, 1'b0, 5'h00, 32'hFFFF_FFFF, 32'h0,         1'b0},
      {1'b0, 1'b1, 5'h00, 32'h0,         32'h7,         1'b0}, // R2
      {1'b1, 1'b0, 5'h01, 32'hFFFF_FFA5, 32'h0,         1'b0},
      {1'b0, 1'b1, 5'h01, 32'h0,         32'hA5,        1'b0}, // R2
      {1'b0, 1'b1, 5'h06, 32'h0,         32'h23,        1'b0}, // R7
      {1'b1, 1'b0, 5'h06, 32'h5,         32'h0,         1'b1}, // R3
      {1'b0, 1'b1, 5'h03, 32'h0,         32'h0,         1'b1}, // R3
      {1'b1, 1'b0, 5'h04, 32'h1,         32'h0,         1'b0}, // R2
      {1'b1, 1'b0, 5'h12, 32'h0,         32'h0,         1'b0}, // R2
      {1'b1, 1'b0, 5'h13, 32'h0,         32'h0,         1'b1}, // R3
      {1'b1, 1'b0, 5'h1A, 32'h0,         32'h0,         1'b1}, // R3
      {1'b0, 1'b1, 5'h10, 32'h0,         32'h0,         1'b1}, // R3
      {1'b0, 1'b1, 5'h0C, 32'h0,         32'h0,         1'b1}, // R3
      {1'b1, 1'b0, 5'h08, 32'h5,         32'h0,         1'b0},
      {1'b0, 1'b1, 5'h08, 32'h0,         32'h5,         1'b0}, // R2
      {1'b1, 1'b0, 5'h19, 32'h0,         32'h0,         1'b0}, // R2
      {1'b0, 1'b1, 5'h1F, 32'h0,         32'h0,         1'b1}  // R3
   };

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] c0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      chk("R1 irq_req", 32'(irq_req), 0);
      chk("R1 dbg_hit", 32'(dbg_hit), 0);
      rd(5'h00); chk("R1 ie", c_rdata, 0); chk("R1 illegal", 32'(c_ill), 0);
      rd(5'h02); chk("R1 ip", c_rdata, 0);
      rd(5'h07); chk("R1 eba", c_rdata, 0);
      rd(5'h08); chk("R1 dc", c_rdata, 0);

      // R2 R3 R7 R10: table walk
      for (int i = 0; i < NV; i++) begin
         csr_wr = VEC[i][71]; csr_rd = VEC[i][70];
         csr_sel = VEC[i][69:65]; csr_wdata = VEC[i][64:33];
         cyc();
         chk($sformatf("R3 vector %0d illegal", i), 32'(c_ill), 32'(VEC[i][0]));
         if (VEC[i][70]) chk($sformatf("R2 vector %0d data", i), c_rdata, VEC[i][32:1]);
      end

      // R6: counter keeps running across a refused write
      rd(5'h05); c0 = c_rdata;
      wr(5'h05, 32'h0); chk("R6 write refused", 32'(c_ill), 1);
      cyc(); cyc(); cyc();
      rd(5'h05); chk("R6 step", c_rdata - c0, 5);

      // R4 R5: ie=7, im=A5 from table
      irq_in = 8'h02; cyc();
      rd(5'h02); chk("R4 ip set", c_rdata, 32'h02); chk("R5 masked", 32'(c_irq), 0);
      irq_in = 8'h01; cyc(); chk("R5 request", 32'(p_irq), 1);
      wr(5'h02, 32'h01);
      rd(5'h02); chk("R4 clear", c_rdata, 32'h02); chk("R5 dropped", 32'(c_irq), 0);
      irq_in = 8'h02; csr_sel = 5'h02; csr_wdata = 32'h02; csr_wr = 1'b1; cyc();
      rd(5'h02); chk("R4 set wins", c_rdata, 32'h02);
      wr(5'h02, 32'h02);
      rd(5'h02); chk("R4 cleared", c_rdata, 32'h0);
      irq_in = 8'h02; cyc();
      wr(5'h01, 32'h02);
      chk("R5 before mask", 32'(c_irq), 0); chk("R5 after mask", 32'(p_irq), 1);
      wr(5'h00, 32'h0); chk("R5 after ie off", 32'(p_irq), 0);
      wr(5'h02, 32'hFF);

      // R8: breakpoints
      wr(5'h10, 32'h0000_1001);
      fetch_pc = 32'h0000_1002; cyc();
      chk("R8 not same cycle", 32'(c_hit), 0); chk("R8 hit", 32'(p_hit), 1);
      cyc(); chk("R8 one cycle", 32'(p_hit), 0);
      wr(5'h11, 32'h0000_2000);
      fetch_pc = 32'h0000_2000; cyc(); chk("R8 disabled slot", 32'(p_hit), 0);
      wr(5'h12, 32'h0000_3001);
      fetch_pc = 32'h0000_3000; cyc(); chk("R8 slot2 hit", 32'(p_hit), 1);
      fetch_pc = 32'h0000_3004; cyc(); chk("R8 next word", 32'(p_hit), 0);

      // R9: watchpoints, dc=5 -> both slots armed for loads
      wr(5'h18, 32'h0000_4000);
      wr(5'h19, 32'h0000_8000);
      data_addr = 32'h4000; data_rd = 1; cyc(); chk("R9 load hit", 32'(p_hit), 1);
      data_addr = 32'h4000; data_wr = 1; cyc(); chk("R9 store ignored", 32'(p_hit), 0);
      wr(5'h08, 32'h8);
      data_addr = 32'h8000; data_wr = 1; cyc(); chk("R9 store hit", 32'(p_hit), 1);
      data_addr = 32'h8000; data_rd = 1; cyc(); chk("R9 load ignored", 32'(p_hit), 0);
      data_addr = 32'h4000; data_rd = 1; cyc(); chk("R9 slot off", 32'(p_hit), 0);
      wr(5'h08, 32'hF);
      data_addr = 32'h4003; data_wr = 1; cyc(); chk("R9 both word", 32'(p_hit), 1);
      data_addr = 32'h8001; data_rd = 1; cyc(); chk("R9 both load", 32'(p_hit), 1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule